// File: doc/BRIEF.md
# Dual-Clock FIFO with Offset Flags

This block is one direction of a bidirectional FIFO pair. Its 36-bit words are written on one clock and read on an unrelated clock. Each side has its own port decode: a LOW chip select, a direction input, a mailbox select that must be LOW, and an enable. Read and write pointers cross between the two clock domains as Gray code through two-stage synchronizers.

The read side has two modes, chosen by a static mode input. In standard mode the read-side flag reports that the storage is not empty. A read strobe moves the oldest word into a separate output register. In fall-through mode the oldest word is loaded into the output register without any read strobe. The read-side flag then reports that the output register holds a valid word, and a read consumes that word. On the write side the same signal acts as the not-full flag in standard mode and as the input-ready flag in fall-through mode.

Two offset flags give early warning. The almost-empty flag is computed in the read domain against offset X. The almost-full flag is computed in the write domain against offset Y. Both offsets are static inputs, and each must be greater than 0 and less than DEPTH/2. Every flag asserts at once in its own domain. Every flag deasserts only after the pointer from the other domain has passed through its synchronizer.

Top module: `xdom_fifo`

## Requirements
- R1: A write is accepted on a rising `wclk` only when `wr_cs_n`=0, `wr_dir`=1, `wr_mbox`=0 and `wr_en`=1. Any other combination stores nothing.
- R2: A read is accepted on a rising `rclk` only when `rd_cs_n`=0, `rd_dir`=1, `rd_mbox`=0 and `rd_en`=1. Any other combination leaves `rd_data` and the stored words unchanged.
- R3: Standard mode (`fwft`=0):
  - `rd_ready` is 1 while the storage holds at least one word.
  - An accepted read loads the oldest word into `rd_data` at that `rclk` edge.
  - `rd_ready` falls right after the read that takes the last word.
- R4: Fall-through mode (`fwft`=1):
  - The oldest word appears on `rd_data` without a read, and `rd_ready`=1 marks it valid.
  - An accepted read replaces it with the next word. If no next word is stored, the read clears `rd_ready`.
- R5: Full behaviour:
  - `wr_ready` goes to 0 right after the write that leaves DEPTH words in storage.
  - Writes while `wr_ready`=0 are dropped and do not disturb the stored words or their order.
- R6: After a read frees a location in a full FIFO, `wr_ready` is still 0 after the first `wclk` edge that follows the read edge, and is 1 after the second.
- R7: A read while `rd_ready`=0 is ignored. Words written afterwards are read back in order.
- R8: Almost-empty flag `rd_aempty_n`:
  - It is 0 while X or fewer words are stored.
  - It falls right after the read that brings the count down to X.
  - After the write that makes X+1 words, it is still 0 after the first `rclk` edge and is 1 after the second.
- R9: Almost-full flag `wr_afull_n`:
  - It is 0 while DEPTH−Y or more words are stored, and falls right after the write that reaches DEPTH−Y.
  - After a read leaves DEPTH−(Y+1) words, it is still 0 after the first `wclk` edge and is 1 after the second.
- R10: The word counts behind the flags exclude a word held in the output register. In fall-through mode, X+1 words written give `rd_aempty_n`=0, and X+2 words give 1.
- R11: While reset is held and just after it is released:
  - `rd_ready`=0 and `wr_ready`=1.
  - `wr_afull_n`=1 and `rd_aempty_n`=0.
  - `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wr_rst | input | 1 | Synchronous reset, write domain |
| rclk | input | 1 | Read clock |
| rd_rst | input | 1 | Synchronous reset, read domain |
| fwft | input | 1 | 1 = fall-through mode, 0 = standard mode (static) |
| ofs_x | input | AW | Almost-empty offset X |
| ofs_y | input | AW | Almost-full offset Y |
| wr_cs_n | input | 1 | Write port select, active LOW |
| wr_dir | input | 1 | 1 selects write |
| wr_mbox | input | 1 | Must be 0 for FIFO access |
| wr_en | input | 1 | Write enable |
| wr_data | input | WIDTH | Write word |
| wr_ready | output | 1 | Not full / input ready |
| wr_afull_n | output | 1 | Almost-full, active LOW |
| rd_cs_n | input | 1 | Read port select, active LOW |
| rd_dir | input | 1 | 1 selects read |
| rd_mbox | input | 1 | Must be 0 for FIFO access |
| rd_en | input | 1 | Read enable |
| rd_data | output | WIDTH | Output register |
| rd_ready | output | 1 | Not empty / output ready |
| rd_aempty_n | output | 1 | Almost-empty, active LOW |

## Verification
The decode is tried with each of the four qualifying inputs wrong in turn. This shows that every term gates the access and that a refused access moves no pointer. Ordered bursts are run in both read modes. They show whether the output register is loaded by the read strobe or by fall-through, and whether a word in that register is counted. Fill-to-full and fill-to-threshold runs separate immediate assertion from synchronized release by counting each edge of the other clock after the releasing access. A dropped extra write and an empty read show that neither disturbs the pointers.

// File: rtl/xdom_fifo_pkg.sv
`timescale 1ns/100ps
package xdom_fifo_pkg;
  typedef logic [31:0] ptr_t;

  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(ptr_t g);
    ptr_t b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // words between two binary pointers (wraps naturally)
  function automatic ptr_t span(ptr_t head, ptr_t tail);
    return head - tail;
  endfunction
endpackage

// File: rtl/xdom_sync2.sv
`timescale 1ns/100ps
module xdom_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xdom_store.sv
`timescale 1ns/100ps
module xdom_store #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/xdom_wr_ctl.sv
`timescale 1ns/100ps
module xdom_wr_ctl
  import xdom_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          wr_rst,
  input  logic          cs_n,
  input  logic          dir,
  input  logic          mbox,
  input  logic          en,
  input  logic [AW-1:0] ofs_y,
  input  logic [PW-1:0] rgray_sync,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] level,
  output logic          ready,
  output logic          afull_n
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  logic [PW-1:0] wptr;
  logic [PW-1:0] rbin;
  logic          req;

  assign req   = !cs_n && dir && !mbox && en;
  assign rbin  = PW'(gray2bin(ptr_t'(rgray_sync)));
  assign level = PW'(span(ptr_t'(wptr), ptr_t'(rbin)));
  assign ready = (level != FULL_LVL);
  assign afull_n = (level < (FULL_LVL - {1'b0, ofs_y}));
  assign push  = req && ready && !wr_rst;
  assign waddr = wptr[AW-1:0];

  always_ff @(posedge wclk) begin
    if (wr_rst) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (push) begin
      wptr  <= wptr + 1'b1;
      wgray <= PW'(bin2gray(ptr_t'(wptr + 1'b1)));
    end
  end
endmodule

// File: rtl/xdom_rd_ctl.sv
`timescale 1ns/100ps
module xdom_rd_ctl
  import xdom_fifo_pkg::*;
#(
  parameter int WIDTH = 36,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             rclk,
  input  logic             rd_rst,
  input  logic             fwft,
  input  logic             cs_n,
  input  logic             dir,
  input  logic             mbox,
  input  logic             en,
  input  logic [AW-1:0]    ofs_x,
  input  logic [PW-1:0]    wgray_sync,
  input  logic [WIDTH-1:0] mem_q,
  output logic [AW-1:0]    raddr,
  output logic [PW-1:0]    rgray,
  output logic [PW-1:0]    level,
  output logic             pop,
  output logic             fetch,
  output logic [WIDTH-1:0] data,
  output logic             ready,
  output logic             aempty_n
);
  logic [PW-1:0] rptr;
  logic [PW-1:0] wbin;
  logic          req;
  logic          stored;
  logic          held;   // output register valid (fall-through mode)

  assign req      = !cs_n && dir && !mbox && en;
  assign wbin     = PW'(gray2bin(ptr_t'(wgray_sync)));
  assign level    = PW'(span(ptr_t'(wbin), ptr_t'(rptr)));
  assign stored   = (level != '0);
  assign aempty_n = (level > {1'b0, ofs_x});
  assign ready    = fwft ? held : stored;
  assign pop      = req && ready && !rd_rst;
  assign fetch    = !rd_rst && stored && (fwft ? (!held || pop) : pop);
  assign raddr    = rptr[AW-1:0];

  always_ff @(posedge rclk) begin
    if (rd_rst) begin
      rptr  <= '0;
      rgray <= '0;
      data  <= '0;
      held  <= 1'b0;
    end else begin
      if (fetch) begin
        data  <= mem_q;
        rptr  <= rptr + 1'b1;
        rgray <= PW'(bin2gray(ptr_t'(rptr + 1'b1)));
      end
      held <= fwft && (fetch || (held && !pop));
    end
  end
endmodule

// File: rtl/xdom_fifo.sv
`timescale 1ns/100ps
module xdom_fifo #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             wclk,
  input  logic             wr_rst,
  input  logic             rclk,
  input  logic             rd_rst,
  input  logic             fwft,
  input  logic [AW-1:0]    ofs_x,
  input  logic [AW-1:0]    ofs_y,
  input  logic             wr_cs_n,
  input  logic             wr_dir,
  input  logic             wr_mbox,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  output logic             wr_afull_n,
  input  logic             rd_cs_n,
  input  logic             rd_dir,
  input  logic             rd_mbox,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_ready,
  output logic             rd_aempty_n
);
  logic             wr_push;
  logic             rd_pop;
  logic             rd_fetch;
  logic [AW-1:0]    waddr;
  logic [AW-1:0]    raddr;
  logic [PW-1:0]    wgray, wgray_rs;
  logic [PW-1:0]    rgray, rgray_ws;
  logic [PW-1:0]    wr_level;
  logic [PW-1:0]    rd_level;
  logic [WIDTH-1:0] mem_q;

  xdom_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .wr_rst(wr_rst), .cs_n(wr_cs_n), .dir(wr_dir),
    .mbox(wr_mbox), .en(wr_en), .ofs_y(ofs_y), .rgray_sync(rgray_ws),
    .push(wr_push), .waddr(waddr), .wgray(wgray), .level(wr_level),
    .ready(wr_ready), .afull_n(wr_afull_n)
  );

  xdom_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst(wr_rst), .d(rgray), .q(rgray_ws));
  xdom_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst(rd_rst), .d(wgray), .q(wgray_rs));

  xdom_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .wclk(wclk), .we(wr_push), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_q)
  );

  xdom_rd_ctl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rd_rst(rd_rst), .fwft(fwft), .cs_n(rd_cs_n), .dir(rd_dir),
    .mbox(rd_mbox), .en(rd_en), .ofs_x(ofs_x), .wgray_sync(wgray_rs),
    .mem_q(mem_q), .raddr(raddr), .rgray(rgray), .level(rd_level),
    .pop(rd_pop), .fetch(rd_fetch), .data(rd_data), .ready(rd_ready),
    .aempty_n(rd_aempty_n)
  );
endmodule

// File: rtl/xdom_fifo_chk.sv
`timescale 1ns/100ps
module xdom_fifo_chk #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input logic             wclk,
  input logic             wr_rst,
  input logic             rclk,
  input logic             rd_rst,
  input logic             fwft,
  input logic             wr_push,
  input logic             wr_ready,
  input logic             wr_afull_n,
  input logic [PW-1:0]    wr_level,
  input logic             rd_pop,
  input logic             rd_ready,
  input logic             rd_aempty_n,
  input logic [PW-1:0]    rd_level,
  input logic [WIDTH-1:0] rd_data
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  p_wr_hold_r1: assert property (@(posedge wclk) disable iff (wr_rst)
    !wr_push |=> (wr_level <= $past(wr_level)));

  p_no_overflow_r5: assert property (@(posedge wclk) disable iff (wr_rst)
    wr_level <= FULL_LVL);

  p_fill_r5: assert property (@(posedge wclk) disable iff (wr_rst)
    (wr_push && wr_level == FULL_LVL - 1'b1) |=> !wr_ready);

  p_afull_release_r9: assert property (@(posedge wclk) disable iff (wr_rst)
    $rose(wr_afull_n) |-> (wr_level < $past(wr_level)));

  p_aempty_release_r8: assert property (@(posedge rclk) disable iff (rd_rst)
    $rose(rd_aempty_n) |-> (rd_level > $past(rd_level)));

  p_no_underflow_r7: assert property (@(posedge rclk) disable iff (rd_rst)
    rd_level <= FULL_LVL);

  p_std_hold_r3: assert property (@(posedge rclk) disable iff (rd_rst)
    (!fwft && !rd_pop) |=> $stable(rd_data));

  p_fwft_hold_r4: assert property (@(posedge rclk) disable iff (rd_rst)
    (fwft && rd_ready && !rd_pop) |=> (rd_ready && $stable(rd_data)));
endmodule

bind xdom_fifo xdom_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .wclk(wclk), .wr_rst(wr_rst), .rclk(rclk), .rd_rst(rd_rst), .fwft(fwft),
  .wr_push(wr_push), .wr_ready(wr_ready), .wr_afull_n(wr_afull_n),
  .wr_level(wr_level), .rd_pop(rd_pop), .rd_ready(rd_ready),
  .rd_aempty_n(rd_aempty_n), .rd_level(rd_level), .rd_data(rd_data)
);

// File: tb/xdom_fifo_test.sv
`timescale 1ns/100ps
module xdom_fifo_test;
  localparam int W  = 36;
  localparam int D  = 16;
  localparam int AW = $clog2(D);
  localparam int X  = 3;
  localparam int Y  = 3;

  logic wclk, rclk, wr_rst, rd_rst, fwft;
  logic wr_cs_n, wr_dir, wr_mbox, wr_en;
  logic rd_cs_n, rd_dir, rd_mbox, rd_en;
  logic [W-1:0] wr_data, rd_data;
  logic wr_ready, wr_afull_n, rd_ready, rd_aempty_n;
  int n_tests = 0;
  int n_fail  = 0;

  xdom_fifo #(.WIDTH(W), .DEPTH(D)) uut (
    .wclk(wclk), .wr_rst(wr_rst), .rclk(rclk), .rd_rst(rd_rst), .fwft(fwft),
    .ofs_x(AW'(X)), .ofs_y(AW'(Y)),
    .wr_cs_n(wr_cs_n), .wr_dir(wr_dir), .wr_mbox(wr_mbox), .wr_en(wr_en),
    .wr_data(wr_data), .wr_ready(wr_ready), .wr_afull_n(wr_afull_n),
    .rd_cs_n(rd_cs_n), .rd_dir(rd_dir), .rd_mbox(rd_mbox), .rd_en(rd_en),
    .rd_data(rd_data), .rd_ready(rd_ready), .rd_aempty_n(rd_aempty_n)
  );

  // 250 MHz write clock (rises at even ns); read clock rises at odd ns
  initial begin wclk = 0; forever #2 wclk = ~wclk; end
  initial begin rclk = 0; #3 rclk = 1; forever begin #3 rclk = 0; #3 rclk = 1; end end

  function automatic logic [W-1:0] pat(int k);
    return {4'hA, 32'(k * 5 + 3)};
  endfunction

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    report();
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_w(int n); repeat (n) @(posedge wclk); #0.5; endtask
  task automatic wait_r(int n); repeat (n) @(posedge rclk); #0.5; endtask

  task automatic wr_acc(logic cs_n, logic dir, logic mb, logic en, logic [W-1:0] d);
    wr_cs_n = cs_n; wr_dir = dir; wr_mbox = mb; wr_en = en; wr_data = d;
    @(posedge wclk); #0.5;
    wr_cs_n = 1; wr_dir = 0; wr_mbox = 0; wr_en = 0;
  endtask
  task automatic wr_word(logic [W-1:0] d); wr_acc(0, 1, 0, 1, d); endtask

  task automatic rd_acc(logic cs_n, logic dir, logic mb, logic en);
    rd_cs_n = cs_n; rd_dir = dir; rd_mbox = mb; rd_en = en;
    @(posedge rclk); #0.5;
    rd_cs_n = 1; rd_dir = 0; rd_mbox = 0; rd_en = 0;
  endtask
  task automatic rd_word(); rd_acc(0, 1, 0, 1); endtask

  task automatic do_reset(logic mode);
    wr_rst = 1; rd_rst = 1; fwft = mode;
    wr_cs_n = 1; wr_dir = 0; wr_mbox = 0; wr_en = 0; wr_data = '0;
    rd_cs_n = 1; rd_dir = 0; rd_mbox = 0; rd_en = 0;
    wait_r(4);
    wr_rst = 0; rd_rst = 0;
    wait_w(2);
    // R11: reset state
    chk("R11", "rd_ready", 64'(rd_ready), 64'd0);
    chk("R11", "wr_ready", 64'(wr_ready), 64'd1);
    chk("R11", "wr_afull_n", 64'(wr_afull_n), 64'd1);
    chk("R11", "rd_aempty_n", 64'(rd_aempty_n), 64'd0);
    chk("R11", "rd_data", 64'(rd_data), 64'd0);
  endtask

  task automatic t_decode();
    do_reset(0);
    wr_acc(1, 1, 0, 1, pat(1));
    wr_acc(0, 0, 0, 1, pat(2));
    wr_acc(0, 1, 1, 1, pat(3));
    wr_acc(0, 1, 0, 0, pat(4));
    wait_r(4);
    chk("R1", "rd_ready after refused writes", 64'(rd_ready), 64'd0);
    wr_word(pat(10));
    wait_r(3);
    chk("R1", "rd_ready after good write", 64'(rd_ready), 64'd1);
    rd_acc(1, 1, 0, 1);
    rd_acc(0, 0, 0, 1);
    rd_acc(0, 1, 1, 1);
    rd_acc(0, 1, 0, 0);
    chk("R2", "rd_data after refused reads", 64'(rd_data), 64'd0);
    chk("R2", "rd_ready after refused reads", 64'(rd_ready), 64'd1);
    rd_word();
    chk("R3", "std read data", 64'(rd_data), 64'(pat(10)));
    chk("R3", "rd_ready after last read", 64'(rd_ready), 64'd0);
    rd_word();
    chk("R7", "rd_data after empty read", 64'(rd_data), 64'(pat(10)));
    wr_word(pat(11));
    wr_word(pat(12));
    wait_r(3);
    rd_word();
    chk("R7", "first word after empty read", 64'(rd_data), 64'(pat(11)));
    rd_word();
    chk("R7", "second word after empty read", 64'(rd_data), 64'(pat(12)));
  endtask

  task automatic t_full();
    do_reset(0);
    for (int i = 0; i < D; i++) wr_word(pat(100 + i));
    chk("R5", "wr_ready at DEPTH words", 64'(wr_ready), 64'd0);
    wr_word(36'hBAD);
    chk("R5", "wr_ready after dropped write", 64'(wr_ready), 64'd0);
    wait_r(3);
    rd_word();
    chk("R3", "first of full run", 64'(rd_data), 64'(pat(100)));
    @(posedge wclk); #0.5;
    chk("R6", "wr_ready after 1st wclk", 64'(wr_ready), 64'd0);
    @(posedge wclk); #0.5;
    chk("R6", "wr_ready after 2nd wclk", 64'(wr_ready), 64'd1);
    for (int i = 1; i < D; i++) begin
      rd_word();
      chk("R5", "order after full", 64'(rd_data), 64'(pat(100 + i)));
    end
    wait_r(3);
    chk("R5", "dropped word not stored", 64'(rd_ready), 64'd0);
  endtask

  task automatic t_almost();
    do_reset(0);
    for (int i = 0; i < X; i++) wr_word(pat(200 + i));
    wait_r(4);
    chk("R8", "aempty_n at X words", 64'(rd_aempty_n), 64'd0);
    wr_word(pat(200 + X));
    @(posedge rclk); #0.5;
    chk("R8", "aempty_n after 1st rclk", 64'(rd_aempty_n), 64'd0);
    @(posedge rclk); #0.5;
    chk("R8", "aempty_n after 2nd rclk", 64'(rd_aempty_n), 64'd1);
    rd_word();
    chk("R8", "aempty_n falls on read to X", 64'(rd_aempty_n), 64'd0);
    wait_w(4);
    for (int i = 0; i < D - Y - X - 1; i++) wr_word(pat(300 + i));
    chk("R9", "afull_n at D-Y-1 words", 64'(wr_afull_n), 64'd1);
    wr_word(pat(399));
    chk("R9", "afull_n falls at D-Y words", 64'(wr_afull_n), 64'd0);
    wait_r(3);
    rd_word();
    @(posedge wclk); #0.5;
    chk("R9", "afull_n after 1st wclk", 64'(wr_afull_n), 64'd0);
    @(posedge wclk); #0.5;
    chk("R9", "afull_n after 2nd wclk", 64'(wr_afull_n), 64'd1);
  endtask

  task automatic t_fwft();
    do_reset(1);
    wr_word(pat(500));
    wait_r(3);
    chk("R4", "rd_ready without read", 64'(rd_ready), 64'd1);
    chk("R4", "word fell through", 64'(rd_data), 64'(pat(500)));
    for (int i = 1; i <= X; i++) wr_word(pat(500 + i));
    wait_r(4);
    chk("R10", "aempty_n with X+1 written", 64'(rd_aempty_n), 64'd0);
    wr_word(pat(500 + X + 1));
    wait_r(4);
    chk("R10", "aempty_n with X+2 written", 64'(rd_aempty_n), 64'd1);
    rd_word();
    chk("R4", "next word after read", 64'(rd_data), 64'(pat(501)));
    chk("R10", "aempty_n after read", 64'(rd_aempty_n), 64'd0);
    for (int i = 2; i <= X + 1; i++) begin
      rd_word();
      chk("R4", "fall-through order", 64'(rd_data), 64'(pat(500 + i)));
    end
    chk("R4", "rd_ready on last held word", 64'(rd_ready), 64'd1);
    rd_word();
    chk("R4", "rd_ready after last consumed", 64'(rd_ready), 64'd0);
  endtask

  initial begin
    t_decode();
    t_full();
    t_almost();
    t_fwft();
    report();
  end
endmodule